// File: doc/BRIEF.md
# Store-Load Overlap Detector

The block remembers every store accepted during the current dispatch group and tests each candidate load against those records. A load that may read bytes written by an earlier store of the same group raises a conflict flag. The scheduler uses that flag to put a no-op in front of the load. The records are discarded when the group closes.

Addresses are compared symbolically, not as full physical addresses. Each memory operand has two 16-bit components and a byte size. The second component is always a base register tag. The first component is either an index register tag or an unsigned constant offset; a flag tells which. A load conflicts with a recorded store in three cases:
- Both components are equal, in the same order.
- Two register components are equal in swapped order.
- Both operands are constant offsets from the same base, and their byte ranges overlap.

All recorded entries are compared in parallel. The flag is combinational from the load query inputs. A store accepted in a cycle is visible to queries from the next cycle onward.

Top module: `store_load_overlap_det`

## Requirements
- R1: After reset the table is empty, and `conflict_o` is 0 for any load query.
- R2: `conflict_o` is 0 whenever `ld_valid_i` is 0, and whenever no store has been recorded in the current group.
- R3: A store presented with `st_valid_i` = 1 is recorded at that clock edge. A load query in the same cycle does not see it; queries from the next cycle onward do.
- R4: A load conflicts with a store record when the constant flags (`*_a_const_i`, 1 = first component is an offset, 0 = it is a register tag) are equal and both components are equal in the same order.
- R5: A load whose two components are register tags conflicts with a register-form store when the load's first equals the store's second and the load's second equals the store's first. Swapped constant-form operands do not match this way.
- R6: When both are constant form and the bases (second components) are equal, there is a conflict if: store offset < load offset and store offset + store size > load offset; or otherwise load offset + load size > store offset. Sums are 17 bits wide, so the comparison never wraps.
- R7: A constant-form operand never matches a register-form operand. Constant-form operands with different bases never conflict.
- R8: The table holds 5 stores per group. A further store in the same group is ignored, and loads matching only that store get no conflict.
- R9: `grp_end_i` discards all records at its clock edge. A store presented in the same cycle is discarded too. A load query in that cycle still sees the old records, and the next group starts empty.
- R10: `conflict_o` is the OR over all valid entries, so a match against any one slot, including the last, raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_end_i | input | 1 | Current dispatch group closes at this edge |
| st_valid_i | input | 1 | Store accepted, record it |
| st_a_const_i | input | 1 | Store first component is a constant offset (1) or a register tag (0) |
| st_a_i | input | 16 | Store first component |
| st_b_i | input | 16 | Store second component (base register tag) |
| st_size_i | input | 5 | Store size in bytes (1, 2, 4, 8, 16) |
| ld_valid_i | input | 1 | Load query present |
| ld_a_const_i | input | 1 | Load first component is a constant offset (1) or a register tag (0) |
| ld_a_i | input | 16 | Load first component |
| ld_b_i | input | 16 | Load second component (base register tag) |
| ld_size_i | input | 5 | Load size in bytes |
| conflict_o | output | 1 | Load overlaps a store recorded in this group |

## Verification
Two functions can land in the same cycle: recording a store and closing the group, and recording a store and answering a load query. The bench drives a store together with `grp_end_i`, then queries that store's address in the next cycle and expects no conflict. It also queries in the closing cycle and expects the old records to still be seen. It drives a store and a matching load in one cycle and expects 0, then expects 1 one cycle later.

// File: rtl/slo_pkg.sv
package slo_pkg;
  localparam int DEF_DEPTH  = 5;
  localparam int DEF_TAG_W  = 16;
  localparam int DEF_SIZE_W = 5;

  typedef enum logic [1:0] {
    HK_NONE  = 2'd0,
    HK_EXACT = 2'd1,
    HK_SWAP  = 2'd2,
    HK_RANGE = 2'd3
  } hit_kind_e;
endpackage

// File: rtl/slo_match.sv
module slo_match #(
  parameter int TAG_W  = slo_pkg::DEF_TAG_W,
  parameter int SIZE_W = slo_pkg::DEF_SIZE_W
) (
  input  logic              e_vld_i,
  input  logic              e_const_i,
  input  logic [TAG_W-1:0]  e_a_i,
  input  logic [TAG_W-1:0]  e_b_i,
  input  logic [SIZE_W-1:0] e_size_i,
  input  logic              ld_vld_i,
  input  logic              ld_const_i,
  input  logic [TAG_W-1:0]  ld_a_i,
  input  logic [TAG_W-1:0]  ld_b_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output slo_pkg::hit_kind_e kind_o
);
  localparam int EXT_W = TAG_W + 1;
  localparam int PAD_W = EXT_W - SIZE_W;

  logic             exact, swap, same_base, both_const, range_hit;
  logic [EXT_W-1:0] e_lo, l_lo, e_hi, l_hi;

  assign exact      = (e_const_i == ld_const_i) && (e_a_i == ld_a_i) && (e_b_i == ld_b_i);
  assign swap       = !e_const_i && !ld_const_i && (e_a_i == ld_b_i) && (e_b_i == ld_a_i);
  assign same_base  = (e_b_i == ld_b_i);
  assign both_const = e_const_i && ld_const_i;

  // one extra bit keeps offset+size from wrapping
  assign e_lo = {1'b0, e_a_i};
  assign l_lo = {1'b0, ld_a_i};
  assign e_hi = e_lo + {{PAD_W{1'b0}}, e_size_i};
  assign l_hi = l_lo + {{PAD_W{1'b0}}, ld_size_i};

  always_comb begin
    range_hit = 1'b0;
    if (same_base && both_const) begin
      if (e_lo < l_lo) range_hit = (e_hi > l_lo);
      else             range_hit = (l_hi > e_lo);
    end
  end

  always_comb begin
    kind_o = slo_pkg::HK_NONE;
    if (e_vld_i && ld_vld_i) begin
      if (exact)          kind_o = slo_pkg::HK_EXACT;
      else if (swap)      kind_o = slo_pkg::HK_SWAP;
      else if (range_hit) kind_o = slo_pkg::HK_RANGE;
    end
  end
endmodule

// File: rtl/slo_table.sv
module slo_table #(
  parameter int DEPTH  = slo_pkg::DEF_DEPTH,
  parameter int TAG_W  = slo_pkg::DEF_TAG_W,
  parameter int SIZE_W = slo_pkg::DEF_SIZE_W,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic                          wr_const_i,
  input  logic [TAG_W-1:0]              wr_a_i,
  input  logic [TAG_W-1:0]              wr_b_i,
  input  logic [SIZE_W-1:0]             wr_size_i,
  output logic [DEPTH-1:0]              vld_o,
  output logic [DEPTH-1:0]              const_o,
  output logic [DEPTH-1:0][TAG_W-1:0]   a_o,
  output logic [DEPTH-1:0][TAG_W-1:0]   b_o,
  output logic [DEPTH-1:0][SIZE_W-1:0]  size_o,
  output logic [CNT_W-1:0]              cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_ok;

  // group end wins over a store in the same cycle
  assign wr_ok = wr_i && !clr_i && (cnt_q < FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_ok) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel;
    assign sel = wr_ok && (cnt_q == CNT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_o[i] <= 1'b0;
      else if (clr_i) vld_o[i] <= 1'b0;
      else if (sel)   vld_o[i] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        const_o[i] <= 1'b0;
        a_o[i]     <= '0;
        b_o[i]     <= '0;
        size_o[i]  <= '0;
      end else if (sel) begin
        const_o[i] <= wr_const_i;
        a_o[i]     <= wr_a_i;
        b_o[i]     <= wr_b_i;
        size_o[i]  <= wr_size_i;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/store_load_overlap_det.sv
module store_load_overlap_det #(
  parameter int DEPTH  = slo_pkg::DEF_DEPTH,
  parameter int TAG_W  = slo_pkg::DEF_TAG_W,
  parameter int SIZE_W = slo_pkg::DEF_SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_end_i,
  input  logic              st_valid_i,
  input  logic              st_a_const_i,
  input  logic [TAG_W-1:0]  st_a_i,
  input  logic [TAG_W-1:0]  st_b_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              ld_valid_i,
  input  logic              ld_a_const_i,
  input  logic [TAG_W-1:0]  ld_a_i,
  input  logic [TAG_W-1:0]  ld_b_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              conflict_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             e_vld, e_const, hit;
  logic [DEPTH-1:0][TAG_W-1:0]  e_a, e_b;
  logic [DEPTH-1:0][SIZE_W-1:0] e_size;
  logic [CNT_W-1:0]             st_cnt;

  slo_table #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (grp_end_i),
    .wr_i      (st_valid_i),
    .wr_const_i(st_a_const_i),
    .wr_a_i    (st_a_i),
    .wr_b_i    (st_b_i),
    .wr_size_i (st_size_i),
    .vld_o     (e_vld),
    .const_o   (e_const),
    .a_o       (e_a),
    .b_o       (e_b),
    .size_o    (e_size),
    .cnt_o     (st_cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    slo_pkg::hit_kind_e kind;
    slo_match #(.TAG_W(TAG_W), .SIZE_W(SIZE_W)) u_m (
      .e_vld_i   (e_vld[i]),
      .e_const_i (e_const[i]),
      .e_a_i     (e_a[i]),
      .e_b_i     (e_b[i]),
      .e_size_i  (e_size[i]),
      .ld_vld_i  (ld_valid_i),
      .ld_const_i(ld_a_const_i),
      .ld_a_i    (ld_a_i),
      .ld_b_i    (ld_b_i),
      .ld_size_i (ld_size_i),
      .kind_o    (kind)
    );
    assign hit[i] = (kind != slo_pkg::HK_NONE);
  end

  assign conflict_o = |hit;
endmodule

// File: rtl/slo_checker.sv
module slo_checker #(
  parameter int DEPTH = slo_pkg::DEF_DEPTH,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             grp_end_i,
  input logic             st_valid_i,
  input logic             ld_valid_i,
  input logic             conflict_o,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= FULL);

  p_full_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !grp_end_i && cnt_i == FULL) |=> (cnt_i == FULL));

  p_store_records_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !grp_end_i && cnt_i < FULL) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  p_group_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_end_i |=> (cnt_i == '0));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |-> !conflict_o);

  p_empty_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !conflict_o);
endmodule

bind store_load_overlap_det slo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .grp_end_i (grp_end_i),
  .st_valid_i(st_valid_i),
  .ld_valid_i(ld_valid_i),
  .conflict_o(conflict_o),
  .cnt_i     (st_cnt)
);

// File: tb/sim_store_load_overlap_det.sv
`timescale 1ns/1ps
module sim_store_load_overlap_det;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        grp_end, st_v, st_c, ld_v, ld_c;
  logic [15:0] st_a, st_b, ld_a, ld_b;
  logic [4:0]  st_s, ld_s;
  logic        conflict;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  bit    exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  store_load_overlap_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .grp_end_i(grp_end),
    .st_valid_i(st_v), .st_a_const_i(st_c), .st_a_i(st_a), .st_b_i(st_b), .st_size_i(st_s),
    .ld_valid_i(ld_v), .ld_a_const_i(ld_c), .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_size_i(ld_s),
    .conflict_o(conflict)
  );

  // monitor: compare one expected item per checked cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_run++;
      if (conflict !== e) begin
        n_fail++;
        $display("FAIL %s: conflict_o=%0b expected %0b", r, conflict, e);
      end
    end
  end

  // one cycle of stimulus; ck pushes an expected conflict value
  task automatic cyc(input bit sv, input bit sc, input logic [15:0] sa, input logic [15:0] sb,
                     input logic [4:0] ss, input bit lv, input bit lc, input logic [15:0] la,
                     input logic [15:0] lb, input logic [4:0] ls, input bit ge,
                     input bit ck, input bit e, input string r);
    st_v = sv; st_c = sc; st_a = sa; st_b = sb; st_s = ss;
    ld_v = lv; ld_c = lc; ld_a = la; ld_b = lb; ld_s = ls;
    grp_end = ge;
    if (ck) begin
      exp_q.push_back(e);
      req_q.push_back(r);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic store(input bit c, input logic [15:0] a, input logic [15:0] b, input logic [4:0] s);
    cyc(1, c, a, b, s, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic query(input bit c, input logic [15:0] a, input logic [15:0] b, input logic [4:0] s,
                       input bit e, input string r);
    cyc(0, 0, 0, 0, 0, 1, c, a, b, s, 0, 1, e, r);
  endtask

  task automatic end_grp();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "");
  endtask

  initial begin
    rst_n = 1'b0;
    grp_end = 0; st_v = 0; st_c = 0; st_a = 0; st_b = 0; st_s = 0;
    ld_v = 0; ld_c = 0; ld_a = 0; ld_b = 0; ld_s = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    query(0, 16'd7, 16'd9, 5'd4, 0, "R1 reset empty");
    query(1, 16'd0, 16'd0, 5'd16, 0, "R1 reset empty const");

    // register-form store, same-cycle load query
    cyc(1, 0, 16'd7, 16'd9, 5'd4, 1, 0, 16'd7, 16'd9, 5'd4, 0, 1, 0, "R3 same cycle unseen");
    query(0, 16'd7, 16'd9, 5'd4, 1, "R3 seen next cycle");
    query(0, 16'd7, 16'd9, 5'd1, 1, "R4 exact match");
    query(0, 16'd9, 16'd7, 5'd4, 1, "R5 swapped registers");
    query(0, 16'd7, 16'd8, 5'd4, 0, "R4 second differs");
    query(1, 16'd7, 16'd9, 5'd4, 0, "R7 const vs register");
    cyc(0, 0, 0, 0, 0, 0, 0, 16'd7, 16'd9, 5'd4, 0, 1, 0, "R2 no load valid");
    end_grp();
    query(0, 16'd7, 16'd9, 5'd4, 0, "R9 cleared at group end");

    // constant-offset stores, base 3
    store(1, 16'h0010, 16'd3, 5'd8);
    query(1, 16'h0017, 16'd3, 5'd1, 1, "R6 store lower overlaps");
    query(1, 16'h0018, 16'd3, 5'd1, 0, "R6 store lower abuts");
    query(1, 16'h000C, 16'd3, 5'd4, 0, "R6 load lower abuts");
    query(1, 16'h000C, 16'd3, 5'd5, 1, "R6 load lower overlaps");
    query(1, 16'h0010, 16'd4, 5'd8, 0, "R7 different base");
    query(1, 16'd3, 16'h0010, 5'd8, 0, "R5 const swap no match");
    store(1, 16'hFFFF, 16'd3, 5'd16);
    query(1, 16'h0000, 16'd3, 5'd1, 0, "R6 no wrap at top");
    query(1, 16'hFFF0, 16'd3, 5'd16, 1, "R6 wide sum overlap");
    end_grp();

    // fill all five slots, then one more
    for (int i = 1; i <= 5; i++) store(0, 16'(i), 16'(20 + i), 5'd4);
    store(0, 16'd6, 16'd26, 5'd4);
    query(0, 16'd5, 16'd25, 5'd4, 1, "R10 last slot hit");
    query(0, 16'd1, 16'd21, 5'd4, 1, "R10 first slot hit");
    query(0, 16'd6, 16'd26, 5'd4, 0, "R8 sixth store ignored");
    // group end + store + query in one cycle
    cyc(1, 0, 16'd30, 16'd31, 5'd4, 1, 0, 16'd1, 16'd21, 5'd4, 1, 1, 1, "R9 old records seen in end cycle");
    query(0, 16'd30, 16'd31, 5'd4, 0, "R9 store with group end dropped");
    query(0, 16'd1, 16'd21, 5'd4, 0, "R9 next group empty");
    store(0, 16'd40, 16'd41, 5'd2);
    query(0, 16'd40, 16'd41, 5'd2, 1, "R9 new group records");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule